// File: doc/BRIEF.md
# UART Receive Wide-Mode Packer

This block sits between a UART receiver core and an 8-bit receive FIFO. Each received character arrives as a single-cycle strobe. The strobe carries up to nine data bits, the parity, framing and break indications, and the framing mode and options that were in force for that character. The block turns the character into a FIFO record. In wide mode the record is two bytes: a data byte, then a status byte with per-character error bits. In plain mode the record is the data byte alone. In 9-bit framing the status byte also carries the ninth data bit, in the place where the parity flag would otherwise be.

Before it writes a record, the block checks that the FIFO has room for all of it. A character that does not fit is dropped whole, and its loss is reported as an overrun. The overrun shows in the status byte of the next record and in a sticky flag set. The sticky flags record any parity, break, framing or overrun event since software last read them. They are not tied to any one byte. A read returns the flags and clears them, but an event that lands in the same cycle as the read is kept.

A controller with three states sequences the writes:
- IDLE waits for a character. It takes a character that was held earlier before it takes a new one. It goes to DATA when the record fits (transition ACCEPT) and stays in IDLE when the character is dropped (transition DROP).
- DATA writes the data byte. It goes to STAT when the record is wide (transition WIDE) and back to IDLE when the record is plain (transition PLAIN_DONE).
- STAT writes the status byte and always goes back to IDLE (transition REC_DONE).

A character that arrives while a record is being written is held in a one-entry slot. A character that arrives while the slot is already occupied is dropped as an overrun.

Top module: `uart_wide_packer`

## Requirements
- R1: In wide mode an accepted character produces exactly two FIFO writes, on consecutive cycles: the data byte first, then the status byte.
- R2: In plain mode (wide_en = 0) an accepted character produces exactly one FIFO write, the data byte.
- R3: Framing mode codes are 00 = 7-bit, 01 = 8-bit, 10 = 9-bit and 11 = 8-bit. In 7-bit mode the data byte is {0, bits[6:0]}. In 8-bit and 9-bit modes it is bits[7:0].
- R4: In 7-bit and 8-bit modes, status bit 0 equals the parity error indication ANDed with parity_en.
- R5: In 9-bit mode, status bit 0 equals received bit 8. The parity indication has no effect on the status byte or on the sticky parity flag.
- R6: Status bit 1 is break, bit 2 is framing error and bit 3 is overrun. Bits 7:4 are always 0.
- R7: A character is written only if fifo_free is at least 2 (wide) or at least 1 (plain). Otherwise it is dropped with no write. The next accepted record then carries status bit 3 = 1, and sticky bit 3 is set.
- R8: A character that arrives while a record is in progress is written after that record, never interleaved with it. A further character that arrives while one is already held is dropped as an overrun (R7 indications).
- R9: The sticky flags are sts_flags[0] parity, [1] break, [2] framing and [3] overrun. Each flag is set by the matching indication of any accepted character, or by a drop.
- R10: While sts_rd is high, sts_flags shows the flags accumulated so far. In the following cycle the flags are cleared, except that a flag set in the same cycle as the read is kept.
- R11: After reset there are no FIFO writes and sts_flags is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_valid | input | 1 | One-cycle strobe: a received character is present |
| char_bits | input | 9 | Received data bits (bit 8 used in 9-bit mode only) |
| char_par_err | input | 1 | Parity error for this character |
| char_frm_err | input | 1 | Framing error for this character |
| char_brk | input | 1 | Break detected for this character |
| frame_mode | input | 2 | Framing mode code (R3) |
| parity_en | input | 1 | Parity checking enabled |
| wide_en | input | 1 | Wide (two-byte) record mode |
| fifo_free | input | FREE_W | Free byte slots in the receive FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write byte |
| sts_rd | input | 1 | Sticky flag read strobe (read clears) |
| sts_flags | output | 4 | Sticky error flags |

## Verification
The hardest path to reach from the ports is the holding slot: a second character must land during DATA, and a third during STAT. That third character is lost, and its overrun must then show in the status byte of the held character, not the first one. The bench drives three strobes on consecutive cycles to force exactly this sequence. The room-based drop is reached by stopping the bench's FIFO consumer until fewer than two slots are free, then sending a wide character. The random phase mixes consumer stalls with random modes, so that drops and the overrun tag that follows them also occur with the other framing options.

// File: rtl/uwp_pkg.sv
package uwp_pkg;

    localparam int CHAR_W = 9;
    localparam int BYTE_W = 8;
    localparam int FLAG_W = 4;

    localparam int ST_PAR = 0;
    localparam int ST_BRK = 1;
    localparam int ST_FRM = 2;
    localparam int ST_OVR = 3;

    typedef enum logic [1:0] {
        MODE_7  = 2'b00,
        MODE_8  = 2'b01,
        MODE_9  = 2'b10,
        MODE_8R = 2'b11
    } frame_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_DATA = 2'b01,
        S_STAT = 2'b10
    } state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] bits;
        logic              par_err;
        logic              frm_err;
        logic              brk;
        frame_e            mode;
        logic              par_en;
        logic              wide;
    } char_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] stat;
        logic              wide;
    } rec_t;

endpackage

// File: rtl/uwp_format.sv
module uwp_format
    import uwp_pkg::*;
(
    input  char_t             ch,
    input  logic              ovr,
    output rec_t              rec,
    output logic [FLAG_W-1:0] err
);

    logic nine;
    logic seven;

    always_comb begin
        nine  = (ch.mode == MODE_9);
        seven = (ch.mode == MODE_7);

        rec.data = ch.bits[BYTE_W-1:0];
        if (seven) begin
            rec.data[BYTE_W-1] = 1'b0;
        end

        rec.stat         = '0;
        rec.stat[ST_PAR] = nine ? ch.bits[CHAR_W-1] : (ch.par_en & ch.par_err);
        rec.stat[ST_BRK] = ch.brk;
        rec.stat[ST_FRM] = ch.frm_err;
        rec.stat[ST_OVR] = ovr;
        rec.wide         = ch.wide;

        err         = '0;
        err[ST_PAR] = ~nine & ch.par_en & ch.par_err;
        err[ST_BRK] = ch.brk;
        err[ST_FRM] = ch.frm_err;
    end

endmodule

// File: rtl/uwp_sticky.sv
module uwp_sticky
    import uwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [FLAG_W-1:0] set,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~{FLAG_W{rd}}) | set;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/uwp_ctrl.sv
module uwp_ctrl
    import uwp_pkg::*;
#(
    parameter int FREE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  char_t             in_ch,
    input  logic [FREE_W-1:0] free,
    output state_e            state,
    output logic              wide_rec,
    output logic              wr,
    output logic [BYTE_W-1:0] wdata,
    output logic [FLAG_W-1:0] sticky_set
);

    state_e            state_q;
    state_e            state_d;
    char_t             pend_q;
    logic              pend_vld_q;
    logic              ovr_q;
    rec_t              rec_q;

    char_t             src;
    logic              src_vld;
    logic [FREE_W-1:0] need;
    logic              room;
    logic              in_idle;
    logic              take;
    logic              drop_room;
    logic              drop_busy;
    logic              drop;
    rec_t              fmt_rec;
    logic [FLAG_W-1:0] fmt_err;

    uwp_format i_fmt (
        .ch  (src),
        .ovr (ovr_q),
        .rec (fmt_rec),
        .err (fmt_err)
    );

    always_comb begin
        src       = pend_vld_q ? pend_q : in_ch;
        src_vld   = pend_vld_q | char_valid;
        need      = src.wide ? FREE_W'(2) : FREE_W'(1);
        room      = (free >= need);
        in_idle   = (state_q == S_IDLE);
        take      = in_idle & src_vld & room;
        drop_room = in_idle & src_vld & ~room;
        drop_busy = ~in_idle & char_valid & pend_vld_q;
        drop      = drop_room | drop_busy;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (take) state_d = S_DATA;
            S_DATA:  state_d = rec_q.wide ? S_STAT : S_IDLE;
            S_STAT:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld_q <= 1'b0;
            pend_q     <= '0;
            ovr_q      <= 1'b0;
            rec_q      <= '0;
        end else begin
            if (in_idle) begin
                if (pend_vld_q) begin
                    pend_vld_q <= char_valid;
                    pend_q     <= in_ch;
                end
            end else if (char_valid && !pend_vld_q) begin
                pend_vld_q <= 1'b1;
                pend_q     <= in_ch;
            end

            if (drop) begin
                ovr_q <= 1'b1;
            end else if (take) begin
                ovr_q <= 1'b0;
            end

            if (take) begin
                rec_q <= fmt_rec;
            end
        end
    end

    always_comb begin
        wr    = 1'b0;
        wdata = '0;
        unique case (state_q)
            S_IDLE: begin
                wr    = 1'b0;
                wdata = '0;
            end
            S_DATA: begin
                wr    = 1'b1;
                wdata = rec_q.data;
            end
            S_STAT: begin
                wr    = 1'b1;
                wdata = rec_q.stat;
            end
            default: begin
                wr    = 1'b0;
                wdata = '0;
            end
        endcase
    end

    always_comb begin
        sticky_set         = fmt_err & {FLAG_W{take}};
        sticky_set[ST_OVR] = drop;
    end

    assign state    = state_q;
    assign wide_rec = rec_q.wide;

endmodule

// File: rtl/uart_wide_packer.sv
module uart_wide_packer
    import uwp_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int FREE_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [8:0]        char_bits,
    input  logic              char_par_err,
    input  logic              char_frm_err,
    input  logic              char_brk,
    input  logic [1:0]        frame_mode,
    input  logic              parity_en,
    input  logic              wide_en,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              fifo_wr,
    output logic [7:0]        fifo_wdata,
    input  logic              sts_rd,
    output logic [3:0]        sts_flags
);

    char_t             in_ch;
    state_e            state;
    logic              wide_rec;
    logic [FLAG_W-1:0] sticky_set;

    always_comb begin
        in_ch.bits    = char_bits;
        in_ch.par_err = char_par_err;
        in_ch.frm_err = char_frm_err;
        in_ch.brk     = char_brk;
        in_ch.mode    = frame_e'(frame_mode);
        in_ch.par_en  = parity_en;
        in_ch.wide    = wide_en;
    end

    uwp_ctrl #(.FREE_W(FREE_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_valid (char_valid),
        .in_ch      (in_ch),
        .free       (fifo_free),
        .state      (state),
        .wide_rec   (wide_rec),
        .wr         (fifo_wr),
        .wdata      (fifo_wdata),
        .sticky_set (sticky_set)
    );

    uwp_sticky i_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (sts_rd),
        .set   (sticky_set),
        .flags (sts_flags)
    );

endmodule

// File: rtl/uwp_checker.sv
module uwp_checker
    import uwp_pkg::*;
#(
    parameter int FREE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_wr,
    input logic [FREE_W-1:0] fifo_free,
    input logic [7:0]        fifo_wdata,
    input state_e            state,
    input logic              wide_rec,
    input logic              sts_rd,
    input logic [3:0]        sts_flags,
    input logic [3:0]        sticky_set
);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_free != '0));

    // R1
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STAT) |-> ($past(state) == S_DATA && fifo_wr));

    // R6
    stat_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && state == S_STAT) |-> (fifo_wdata[7:4] == 4'h0));

    // R2
    plain_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && !wide_rec) |=> (state == S_IDLE));

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && sticky_set == 4'h0) |=> (sts_flags == 4'h0));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_set != 4'h0) |=> ((sts_flags & $past(sticky_set)) == $past(sticky_set)));

endmodule

bind uart_wide_packer uwp_checker #(.FREE_W(FREE_W)) i_uwp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_wr    (fifo_wr),
    .fifo_free  (fifo_free),
    .fifo_wdata (fifo_wdata),
    .state      (state),
    .wide_rec   (wide_rec),
    .sts_rd     (sts_rd),
    .sts_flags  (sts_flags),
    .sticky_set (sticky_set)
);

// File: tb/test_uart_wide_packer.sv
module test_uart_wide_packer;

    localparam int DEPTH  = 8;
    localparam int FREE_W = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              char_valid = 1'b0;
    logic [8:0]        char_bits = '0;
    logic              char_par_err = 1'b0;
    logic              char_frm_err = 1'b0;
    logic              char_brk = 1'b0;
    logic [1:0]        frame_mode = 2'b01;
    logic              parity_en = 1'b0;
    logic              wide_en = 1'b1;
    logic [FREE_W-1:0] fifo_free;
    logic              fifo_wr;
    logic [7:0]        fifo_wdata;
    logic              sts_rd = 1'b0;
    logic [3:0]        sts_flags;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int count = 0;
    logic pop = 1'b0;
    logic pop_en = 1'b1;
    logic [3:0] exp_sticky = '0;
    logic exp_ovr = 1'b0;
    logic [7:0] got_q[$];
    int got_cyc[$];
    logic [7:0] exp_q[$];

    uart_wide_packer #(.FIFO_DEPTH(DEPTH)) i_uart_wide_packer (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_bits(char_bits),
        .char_par_err(char_par_err), .char_frm_err(char_frm_err), .char_brk(char_brk),
        .frame_mode(frame_mode), .parity_en(parity_en), .wide_en(wide_en),
        .fifo_free(fifo_free), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .sts_rd(sts_rd), .sts_flags(sts_flags)
    );

    always #10 clk = ~clk;

    assign fifo_free = FREE_W'(DEPTH - count);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) count <= 0;
        else count <= count + (fifo_wr ? 1 : 0) - (pop ? 1 : 0);
    end

    always @(negedge clk) begin
        pop = pop_en && (count != 0) && ($urandom_range(0, 1) == 1);
        if (rst_n && fifo_wr) begin
            got_q.push_back(fifo_wdata);
            got_cyc.push_back(cyc);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] e_data(input logic [1:0] md, input logic [8:0] d);
        e_data = (md == 2'b00) ? {1'b0, d[6:0]} : d[7:0];
    endfunction

    function automatic logic [7:0] e_stat(input logic [1:0] md, input logic [8:0] d,
            input logic pe, input logic pa, input logic fr, input logic br, input logic ov);
        logic b0;
        b0 = (md == 2'b10) ? d[8] : (pe & pa);
        e_stat = {4'b0000, ov, fr, br, b0};
    endfunction

    function automatic logic [3:0] e_err(input logic [1:0] md, input logic pe,
            input logic pa, input logic fr, input logic br);
        e_err = {1'b0, fr, br, (md != 2'b10) & pe & pa};
    endfunction

    task automatic drive(input logic [8:0] d, input logic pe, input logic pa,
            input logic fr, input logic br, input logic [1:0] md, input logic wd);
        char_valid = 1'b1;
        char_bits = d; parity_en = pe; char_par_err = pa;
        char_frm_err = fr; char_brk = br; frame_mode = md; wide_en = wd;
    endtask

    task automatic predict(input logic [8:0] d, input logic pe, input logic pa,
            input logic fr, input logic br, input logic [1:0] md, input logic wd,
            input int free_now);
        if (free_now >= (wd ? 2 : 1)) begin
            exp_q.push_back(e_data(md, d));
            if (wd) exp_q.push_back(e_stat(md, d, pe, pa, fr, br, exp_ovr));
            exp_ovr = 1'b0;
            exp_sticky = exp_sticky | e_err(md, pe, pa, fr, br);
        end else begin
            exp_ovr = 1'b1;
            exp_sticky[3] = 1'b1;
        end
    endtask

    task automatic compare(input string tag);
        int n;
        chk({tag, " write count"}, got_q.size(), exp_q.size());
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++) chk({tag, " byte"}, got_q[i], exp_q[i]);
        got_q.delete(); got_cyc.delete(); exp_q.delete();
    endtask

    task automatic send(input logic [8:0] d, input logic pe, input logic pa,
            input logic fr, input logic br, input logic [1:0] md, input logic wd,
            input string tag);
        @(negedge clk);
        drive(d, pe, pa, fr, br, md, wd);
        predict(d, pe, pa, fr, br, md, wd, int'(fifo_free));
        @(negedge clk);
        char_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (got_q.size() == 2) chk("R1 consecutive", got_cyc[1] - got_cyc[0], 1);
        compare(tag);
    endtask

    task automatic read_sticky(input string tag);
        @(negedge clk);
        sts_rd = 1'b1;
        chk({tag, " read value"}, sts_flags, exp_sticky);
        @(negedge clk);
        sts_rd = 1'b0;
        exp_sticky = '0;
        chk("R10 cleared", sts_flags, 4'h0);
    endtask

    task automatic drain;
        pop_en = 1'b1;
        while (count != 0) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R11 no write in reset", fifo_wr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 no write after reset", fifo_wr, 0);
        chk("R11 flags zero", sts_flags, 4'h0);

        send(9'h0C3, 1, 1, 0, 0, 2'b01, 1, "R4");
        send(9'h0C3, 0, 1, 0, 0, 2'b01, 1, "R4");
        send(9'h1FF, 1, 0, 0, 0, 2'b00, 1, "R3");
        send(9'h0A5, 0, 0, 0, 0, 2'b11, 1, "R3");
        read_sticky("R9");
        send(9'h1A5, 1, 1, 0, 0, 2'b10, 1, "R5");
        send(9'h0A5, 1, 1, 0, 0, 2'b10, 1, "R5");
        chk("R5 no sticky parity", sts_flags, 4'h0);
        send(9'h05A, 0, 0, 1, 1, 2'b01, 1, "R6");
        send(9'h133, 1, 1, 1, 0, 2'b01, 0, "R2");
        read_sticky("R9");

        // R7: stall consumer until fewer than two slots are free
        pop_en = 1'b0;
        @(negedge clk);
        while (count < DEPTH - 1) send(9'h011, 0, 0, 0, 0, 2'b01, 0, "R7");
        chk("R7 fifo nearly full", fifo_free, 1);
        send(9'h0EE, 0, 0, 0, 0, 2'b01, 1, "R7");
        chk("R7 sticky overrun", sts_flags[3], 1);
        drain();
        send(9'h077, 0, 0, 0, 0, 2'b01, 1, "R7");
        read_sticky("R7");

        // R8: three characters on consecutive cycles
        drain();
        @(negedge clk);
        drive(9'h031, 0, 0, 0, 0, 2'b01, 1);
        predict(9'h031, 0, 0, 0, 0, 2'b01, 1, DEPTH);
        @(negedge clk);
        drive(9'h042, 0, 0, 0, 0, 2'b01, 1);
        @(negedge clk);
        drive(9'h053, 0, 0, 1, 0, 2'b01, 1);
        exp_ovr = 1'b1; exp_sticky[3] = 1'b1;
        predict(9'h042, 0, 0, 0, 0, 2'b01, 1, DEPTH);
        @(negedge clk);
        char_valid = 1'b0;
        repeat (8) @(negedge clk);
        if (got_q.size() == 4) begin
            chk("R8 first pair consecutive", got_cyc[1] - got_cyc[0], 1);
            chk("R8 second pair consecutive", got_cyc[3] - got_cyc[2], 1);
        end
        compare("R8");
        read_sticky("R8");

        // R10: event in the same cycle as the read
        drain();
        @(negedge clk);
        sts_rd = 1'b1;
        drive(9'h066, 0, 0, 1, 0, 2'b01, 1);
        predict(9'h066, 0, 0, 1, 0, 2'b01, 1, int'(fifo_free));
        chk("R10 read shows old", sts_flags, 4'h0);
        @(negedge clk);
        sts_rd = 1'b0; char_valid = 1'b0;
        chk("R10 simultaneous kept", sts_flags, 4'b0100);
        repeat (4) @(negedge clk);
        compare("R10");
        read_sticky("R9");

        // random phase
        for (int k = 0; k < 300; k++) begin
            pop_en = ($urandom_range(0, 3) != 0);
            send(9'($urandom_range(0, 511)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) != 0), "R6 random");
            if (k % 25 == 24) read_sticky("R9 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule